// File: doc/BRIEF.md
# Atomic Event Mode Escalation Controller

This per-core controller carries one multi-address atomic event to completion by moving through up to three execution modes. Each event starts as a speculative attempt. If that attempt fails, the controller runs the event again in strict program order. If the in-order run also fails, the controller asks a central granter to hand it ownership of every address in the event. Once the granter agrees, the controller refuses interfering snoops, so the final run is bound to finish.

Software or the core first streams the event's addresses into a small local list through a valid/ready port. The port holds back (`ld_ready` low) while an event is running or once the list is full, and an address is taken only in a cycle where both `ld_valid` and `ld_ready` are high. A start pulse then launches the event. In the in-order and granted modes the addresses leave on a valid/ready issue port. Once `iss_valid` rises, `iss_addr` holds steady until `iss_ready` accepts it. The memory pipeline reports each attempt's outcome through a one-cycle result pulse carrying a fail flag. When the event finishes, the controller gives a done pulse with a code that names the winning mode. If the granted mode was used, the granter is told to release the addresses in that same cycle.

Top module: `atomic_escalator`

## Requirements
- R1: While idle, `ld_ready` is high as long as fewer than MAX_ADDR (8) addresses are held. Each accepted beat is appended in arrival order. When the list is full, `ld_ready` is low and an offered beat is not stored.
- R2: A `start` pulse while idle with at least one address stored makes `spec_go` high for exactly the next cycle, with `exec_mode` = 2'b01 (optimistic). A `start` with an empty list is ignored.
- R3: A successful result in optimistic mode gives `done` for one cycle, in the cycle after the result, with `done_mode` = 2'b01. The address list is emptied at the same time.
- R4: A failed optimistic result switches to in-order mode (`exec_mode` = 2'b10). Every stored address is then offered on the issue port in load order, one per handshake, and `iss_addr` is held stable while `iss_ready` is low.
- R5: A failed in-order result raises `gnt_req`, with `gnt_addrs` carrying entry i in bits [i*32 +: 32] and `gnt_cnt` giving the count. `gnt_req` stays high through any number of denials, and the mode never returns to 01 or 10.
- R6: After `gnt_ack` without `gnt_deny`, `exec_mode` = 2'b11 and `nak_en` stays high until completion. The addresses are issued again in load order. `nak_en` is low in every other state.
- R7: A result in granted mode always completes the event, whatever its fail flag. It gives `done` with `done_mode` = 2'b11 and a one-cycle `gnt_release` in that same cycle.
- R8: A successful in-order result gives `done` with `done_mode` = 2'b10 in the cycle after the result.
- R9: While an event is running, `ld_ready` is low and `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Address beat offered |
| ld_ready | output | 1 | Address beat can be taken |
| ld_addr | input | AW | Address to append |
| start | input | 1 | Launch the event |
| spec_go | output | 1 | One-cycle launch of the speculative attempt |
| exec_mode | output | 2 | Current mode: 00 idle, 01 optimistic, 10 in-order, 11 granted |
| iss_valid | output | 1 | Ordered access offered |
| iss_ready | input | 1 | Pipeline accepts the access |
| iss_addr | output | AW | Address of the ordered access |
| res_valid | input | 1 | Attempt outcome pulse |
| res_fail | input | 1 | Attempt failed |
| gnt_req | output | 1 | Ownership request to the granter |
| gnt_addrs | output | MAX_ADDR*AW | All event addresses, entry i at [i*AW +: AW] |
| gnt_cnt | output | CW | Number of valid entries |
| gnt_ack | input | 1 | Granter accepts |
| gnt_deny | input | 1 | Granter refuses this cycle |
| gnt_release | output | 1 | Release held addresses |
| nak_en | output | 1 | Refuse interfering snoops |
| done | output | 1 | Event completed |
| done_mode | output | 2 | Mode that completed the event |

## Verification
The hardest state to reach is the granted mode after several denials. To get there, both the speculative and the in-order attempts have to fail, and the granter has to refuse a number of times before it agrees. The bench draws both failure flags, the denial count and the issue back-pressure from a seeded random source, so every completion path is covered. Directed cases add a full list with a ninth beat offered, a start with an empty list, and a start pulsed while an event is running.

// File: rtl/aem_pkg.sv
package aem_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_OPT  = 2'b01,
    MODE_SEQ  = 2'b10,
    MODE_GNT  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OPT_GO, S_OPT_WAIT, S_SEQ_ISS, S_SEQ_WAIT,
    S_GREQ, S_GNT_ISS, S_GNT_WAIT
  } ctl_state_e;

  function automatic mode_e mode_of(ctl_state_e s);
    case (s)
      S_OPT_GO, S_OPT_WAIT: return MODE_OPT;
      S_SEQ_ISS, S_SEQ_WAIT: return MODE_SEQ;
      S_GREQ, S_GNT_ISS, S_GNT_WAIT: return MODE_GNT;
      default: return MODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/aem_addr_file.sv
module aem_addr_file #(
  parameter int AW = 32,
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_data,
  input  logic            clear,
  input  logic [IW-1:0]   rd_idx,
  output logic [AW-1:0]   rd_data,
  output logic [CW-1:0]   count,
  output logic [N*AW-1:0] flat
);
  logic [AW-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (wr_en) regs[count[IW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (wr_en)      count <= count + CW'(1);
  end

  assign rd_data = regs[rd_idx];

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign flat[g*AW +: AW] = regs[g];
  end
endmodule

// File: rtl/aem_issue_ctr.sv
module aem_issue_ctr #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          fire,
  input  logic [CW-1:0] count,
  output logic [IW-1:0] idx,
  output logic          last
);
  assign last = (CW'(idx) + CW'(1)) == count;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) idx <= '0;
    else if (fire)         idx <= last ? '0 : idx + IW'(1);
  end
endmodule

// File: rtl/aem_fsm.sv
module aem_fsm
  import aem_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] count,
  input  logic          iss_fire,
  input  logic          last,
  input  logic          res_valid,
  input  logic          res_fail,
  input  logic          gnt_ack,
  input  logic          gnt_deny,
  output ctl_state_e    state,
  output logic          fin,
  output logic          done,
  output mode_e         done_mode,
  output logic          gnt_release
);
  ctl_state_e nxt;
  mode_e      fin_mode;

  always_comb begin
    nxt      = state;
    fin      = 1'b0;
    fin_mode = MODE_NONE;
    case (state)
      S_IDLE:     if (start && count != '0) nxt = S_OPT_GO;
      S_OPT_GO:   nxt = S_OPT_WAIT;
      S_OPT_WAIT: if (res_valid) begin
        if (res_fail) nxt = S_SEQ_ISS;
        else begin fin = 1'b1; fin_mode = MODE_OPT; nxt = S_IDLE; end
      end
      S_SEQ_ISS:  if (iss_fire && last) nxt = S_SEQ_WAIT;
      S_SEQ_WAIT: if (res_valid) begin
        if (res_fail) nxt = S_GREQ;
        else begin fin = 1'b1; fin_mode = MODE_SEQ; nxt = S_IDLE; end
      end
      S_GREQ:     if (gnt_ack && !gnt_deny) nxt = S_GNT_ISS;
      S_GNT_ISS:  if (iss_fire && last) nxt = S_GNT_WAIT;
      S_GNT_WAIT: if (res_valid) begin
        fin = 1'b1; fin_mode = MODE_GNT; nxt = S_IDLE;
      end
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      done        <= 1'b0;
      done_mode   <= MODE_NONE;
      gnt_release <= 1'b0;
    end else begin
      state       <= nxt;
      done        <= fin;
      done_mode   <= fin_mode;
      gnt_release <= fin && (fin_mode == MODE_GNT);
    end
  end
endmodule

// File: rtl/atomic_escalator.sv
module atomic_escalator
  import aem_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MAX_ADDR = 8,
  localparam int IW = (MAX_ADDR > 1) ? $clog2(MAX_ADDR) : 1,
  localparam int CW = $clog2(MAX_ADDR + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [AW-1:0]         ld_addr,
  input  logic                  start,
  output logic                  spec_go,
  output logic [1:0]            exec_mode,
  output logic                  iss_valid,
  input  logic                  iss_ready,
  output logic [AW-1:0]         iss_addr,
  input  logic                  res_valid,
  input  logic                  res_fail,
  output logic                  gnt_req,
  output logic [MAX_ADDR*AW-1:0] gnt_addrs,
  output logic [CW-1:0]         gnt_cnt,
  input  logic                  gnt_ack,
  input  logic                  gnt_deny,
  output logic                  gnt_release,
  output logic                  nak_en,
  output logic                  done,
  output logic [1:0]            done_mode
);
  ctl_state_e    state;
  mode_e         dmode;
  logic          fin, last, iss_fire, issuing;
  logic [CW-1:0] count;
  logic [IW-1:0] idx;

  assign issuing  = (state == S_SEQ_ISS) || (state == S_GNT_ISS);
  assign iss_valid = issuing;
  assign iss_fire = issuing && iss_ready;
  assign ld_ready = (state == S_IDLE) && (count < CW'(MAX_ADDR));
  assign spec_go  = (state == S_OPT_GO);
  assign exec_mode = mode_of(state);
  assign gnt_req  = (state == S_GREQ);
  assign gnt_cnt  = count;
  assign nak_en   = (state == S_GNT_ISS) || (state == S_GNT_WAIT);
  assign done_mode = dmode;

  aem_addr_file #(.AW(AW), .N(MAX_ADDR)) u_list (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_valid && ld_ready), .wr_data(ld_addr),
    .clear(fin), .rd_idx(idx), .rd_data(iss_addr), .count(count), .flat(gnt_addrs)
  );

  aem_issue_ctr #(.N(MAX_ADDR)) u_ctr (
    .clk(clk), .rst_n(rst_n), .active(issuing), .fire(iss_fire),
    .count(count), .idx(idx), .last(last)
  );

  aem_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count), .iss_fire(iss_fire),
    .last(last), .res_valid(res_valid), .res_fail(res_fail), .gnt_ack(gnt_ack),
    .gnt_deny(gnt_deny), .state(state), .fin(fin), .done(done),
    .done_mode(dmode), .gnt_release(gnt_release)
  );
endmodule

// File: rtl/aem_checker.sv
module aem_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_ready,
  input logic          spec_go,
  input logic [1:0]    exec_mode,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic [AW-1:0] iss_addr,
  input logic          gnt_req,
  input logic          gnt_ack,
  input logic          gnt_deny,
  input logic          gnt_release,
  input logic          nak_en,
  input logic          done,
  input logic [1:0]    done_mode
);
  p_spec_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spec_go |=> !spec_go && exec_mode == 2'b01);
  p_spec_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spec_go |-> exec_mode == 2'b01);
  p_done_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_mode != 2'b00);
  p_iss_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_addr));
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_req && !(gnt_ack && !gnt_deny) |=> gnt_req && exec_mode == 2'b11);
  p_nak_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nak_en |-> exec_mode == 2'b11 && !gnt_req);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_release |-> done && done_mode == 2'b11);
  p_busy_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> exec_mode == 2'b00);
endmodule

bind atomic_escalator aem_checker #(.AW(AW)) u_aem_checker (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready), .spec_go(spec_go),
  .exec_mode(exec_mode), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_addr(iss_addr), .gnt_req(gnt_req), .gnt_ack(gnt_ack), .gnt_deny(gnt_deny),
  .gnt_release(gnt_release), .nak_en(nak_en), .done(done), .done_mode(done_mode)
);

// File: tb/test_atomic_escalator.sv
module test_atomic_escalator;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, start = 0, iss_ready = 0, res_valid = 0, res_fail = 0;
  logic gnt_ack = 0, gnt_deny = 0;
  logic [31:0] ld_addr = '0;
  logic ld_ready, spec_go, iss_valid, gnt_req, gnt_release, nak_en, done;
  logic [1:0] exec_mode, done_mode;
  logic [31:0] iss_addr;
  logic [N*32-1:0] gnt_addrs;
  logic [3:0] gnt_cnt;

  int checks = 0, failures = 0, cycles = 0;
  logic [31:0] a [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_escalator i_atomic_escalator (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .start(start), .spec_go(spec_go), .exec_mode(exec_mode), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_addr(iss_addr), .res_valid(res_valid), .res_fail(res_fail),
    .gnt_req(gnt_req), .gnt_addrs(gnt_addrs), .gnt_cnt(gnt_cnt), .gnt_ack(gnt_ack),
    .gnt_deny(gnt_deny), .gnt_release(gnt_release), .nak_en(nak_en), .done(done),
    .done_mode(done_mode)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input bit f_opt, input bit f_seq);
    if (!f_opt) return 2'b01;
    if (!f_seq) return 2'b10;
    return 2'b11;
  endfunction

  task automatic stream(input int n, input logic [1:0] m, input bit bp);
    for (int i = 0; i < n; i++) begin
      bit r = 0;
      while (!r) begin
        chk(iss_valid === 1'b1 && iss_addr === a[i], (m == 2'b11) ? "R6 issue order" : "R4 issue order", iss_addr, a[i]);
        chk(exec_mode === m, (m == 2'b11) ? "R6 mode" : "R4 mode", exec_mode, m);
        if (m == 2'b11) chk(nak_en === 1'b1, "R6 nak held", nak_en, 1);
        else            chk(nak_en === 1'b0, "R6 nak low", nak_en, 0);
        r = bp ? bit'($urandom % 2) : 1'b1;
        iss_ready = r;
        @(negedge clk);
      end
    end
    iss_ready = 0;
    chk(iss_valid === 1'b0, "R4 stream end", iss_valid, 0);
  endtask

  task automatic finish_chk(input logic [1:0] code);
    chk(done === 1'b1 && done_mode === code,
        (code == 2'b01) ? "R3 done code" : (code == 2'b10) ? "R8 done code" : "R7 done code",
        {done, done_mode}, {1'b1, code});
    chk(gnt_release === (code == 2'b11), "R7 release", gnt_release, code == 2'b11);
    @(negedge clk);
    chk(done === 1'b0 && gnt_release === 1'b0 && nak_en === 1'b0 && exec_mode === 2'b00,
        "R7 back to idle", {done, gnt_release, nak_en, exec_mode}, 0);
    chk(ld_ready === 1'b1, "R3 list emptied", ld_ready, 1);
  endtask

  task automatic run_event(input int n, input bit f_opt, input bit f_seq, input int deny_n,
                           input bit bp, input bit probe_busy, input bit try_extra);
    logic [1:0] code = exp_code(f_opt, f_seq);
    for (int i = 0; i < n; i++) begin
      ld_valid = 1; ld_addr = a[i];
      chk(ld_ready === 1'b1, "R1 ready while room", ld_ready, 1);
      @(negedge clk);
    end
    if (try_extra) begin
      ld_addr = 32'hDEAD_BEEF;
      chk(ld_ready === 1'b0, "R1 full list", ld_ready, 0);
      @(negedge clk);
    end
    ld_valid = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(spec_go === 1'b1 && exec_mode === 2'b01, "R2 launch", {spec_go, exec_mode}, 3'b101);
    @(negedge clk);
    chk(spec_go === 1'b0, "R2 one-cycle launch", spec_go, 0);
    if (probe_busy) begin
      chk(ld_ready === 1'b0, "R9 busy no load", ld_ready, 0);
      start = 1;
      @(negedge clk);
      start = 0;
      chk(spec_go === 1'b0 && exec_mode === 2'b01, "R9 start ignored", {spec_go, exec_mode}, 1);
    end
    res_valid = 1; res_fail = f_opt;
    @(negedge clk);
    res_valid = 0; res_fail = 0;
    if (!f_opt) begin finish_chk(code); return; end
    stream(n, 2'b10, bp);
    res_valid = 1; res_fail = f_seq;
    @(negedge clk);
    res_valid = 0; res_fail = 0;
    if (!f_seq) begin finish_chk(code); return; end
    chk(gnt_req === 1'b1 && gnt_cnt === 4'(n), "R5 request count", {gnt_req, gnt_cnt}, {1'b1, 4'(n)});
    for (int i = 0; i < n; i++)
      chk(gnt_addrs[i*32 +: 32] === a[i], "R5 request addresses", gnt_addrs[i*32 +: 32], a[i]);
    for (int d = 0; d < deny_n; d++) begin
      gnt_deny = 1;
      @(negedge clk);
      chk(gnt_req === 1'b1 && exec_mode === 2'b11 && nak_en === 1'b0, "R5 hold after deny",
          {gnt_req, exec_mode, nak_en}, 4'b1110);
    end
    gnt_deny = 0; gnt_ack = 1;
    @(negedge clk);
    gnt_ack = 0;
    chk(nak_en === 1'b1 && gnt_req === 1'b0, "R6 grant taken", {nak_en, gnt_req}, 2'b10);
    stream(n, 2'b11, bp);
    chk(nak_en === 1'b1, "R6 nak while waiting", nak_en, 1);
    res_valid = 1; res_fail = bit'($urandom % 2);
    @(negedge clk);
    res_valid = 0; res_fail = 0;
    finish_chk(code);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ld_ready === 1'b1 && done === 1'b0 && exec_mode === 2'b00 && gnt_req === 1'b0 &&
        nak_en === 1'b0 && iss_valid === 1'b0, "R1 reset state",
        {ld_ready, done, exec_mode, gnt_req, nak_en, iss_valid}, 7'b1000000);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(spec_go === 1'b0 && exec_mode === 2'b00, "R2 empty start ignored", {spec_go, exec_mode}, 0);

    for (int i = 0; i < N; i++) a[i] = 32'h1000_0000 + 32'(i) * 32'h40;
    run_event(N, 1, 1, 3, 1, 1, 1);
    run_event(1, 0, 0, 0, 0, 1, 0);
    run_event(1, 1, 0, 0, 0, 0, 0);
    run_event(2, 1, 1, 0, 0, 0, 0);

    for (int t = 0; t < 60; t++) begin
      int n = 1 + int'($urandom % N);
      for (int i = 0; i < N; i++) a[i] = $urandom;
      run_event(n, bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 5),
                bit'($urandom % 2), bit'($urandom % 4 == 0), n == N);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule